// File: doc/BRIEF.md
# PCI Bus Latency Rule Monitor

This block watches a conventional parallel PCI bus from inside a host that also arbitrates the bus. On every PCI clock it samples FRAME#, IRDY#, TRDY# and STOP#. From these it follows each transaction through its data phases and times the wait for the target and the wait for the master. If a target answers late, or a master signals ready late, the block sets a sticky flag in a small status register. A mask register with the same bit layout decides whether each flag drives the interrupt line. The monitor never drives the bus.

In the requirements, clock 0 is the clock on which FRAME# is first sampled asserted. Clock k is the k-th rising edge after a reference clock. The reference is clock 0 for the first data phase and the completing clock of the previous data phase for later phases. The limits are exact: a response on the last allowed clock is legal. Software reaches the two registers through a single-cycle port. Writes take effect at the clock edge. Reads are combinational.

Top module: `pci_lat_monitor`

## Requirements
- R1: For the first data phase, if neither TRDY# nor STOP# has been asserted on any clock up to and including clock 16, status bit 12 is set at the edge that samples clock 16. A TRDY# or STOP# on clock 16 or earlier sets nothing.
- R2: For the second and later data phases, the target limit is 8 clocks after the previous phase completed. Bit 12 is set only if TRDY# and STOP# both stay deasserted through clock 8.
- R3: For the first data phase, if IRDY# is not asserted by clock 8 after FRAME# is first asserted, status bit 11 is set at the edge that samples clock 8. IRDY# on clock 8 is legal.
- R4: For the second and later data phases, the master limit is 8 clocks after the previous phase completed. Bit 11 is set only if IRDY# stays deasserted through clock 8.
- R5: Register address 0 holds status and address 1 holds mask. In both, bit 12 is the target flag and bit 11 is the master flag. All other bits, and all other addresses, read as zero. Reads are combinational on reg_addr.
- R6: A mask bit at 1 keeps the matching flag from reaching irq. The status bit is still set.
- R7: Writing 1 to a status bit at address 0 clears it, and writing 0 leaves it unchanged. A breach on the same clock as a clear leaves the bit set.
- R8: Each kind of breach is reported at most once per data phase. In a hung phase, a flag cleared after the breach stays clear until the phase completes.
- R9: A data phase completes on a clock where IRDY# is asserted together with TRDY# or STOP#, and both timers restart from that clock. A transaction ends on the first clock with FRAME# and IRDY# both deasserted after a completed phase. Between transactions no flag is set, however long the bus stays idle.
- R10: After reset the status reads 0, the mask reads 0x1800 (both flags masked), and irq is 0.
- R11: irq is 1 exactly when a status bit is 1 and its mask bit is 0. It follows the registers within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| trdy_n | input | 1 | Sampled TRDY#, active low |
| stop_n | input | 1 | Sampled STOP#, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 mask) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq | output | 1 | Unmasked latency breach interrupt |

## Verification
The bench places target and master responses on the last legal clock and on the clock after it, both in the first phase and in later phases, and responds with STOP# as well as TRDY#. A design that reports one clock early fails on the legal cases, and a design that reports one clock late misses the breach case. A clear is written on the very clock of a breach to catch a design in which the clear wins over the new event. A hung phase is cleared part way through to catch a counter that wraps, or a flag that is set again and again. Long idle periods and back-to-back transactions show whether the timers keep running outside a transaction or fail to restart at each completed phase.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;

    // Flag positions shared by the status and mask registers
    localparam int TGT_FLAG_BIT = 12;
    localparam int MST_FLAG_BIT = 11;

    // Register addresses
    localparam int REG_STATUS_ADDR = 0;
    localparam int REG_MASK_ADDR   = 1;

    // Bus signals after conversion to active-high
    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
    } bus_smp_t;

    // One bit per breach kind
    typedef struct packed {
        logic tgt;
        logic mst;
    } lat_flags_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_t;

    function automatic bus_smp_t decode_bus(input logic frame_n, input logic irdy_n,
                                            input logic trdy_n, input logic stop_n);
        bus_smp_t s;
        s.frame = ~frame_n;
        s.irdy  = ~irdy_n;
        s.trdy  = ~trdy_n;
        s.stop  = ~stop_n;
        return s;
    endfunction

    function automatic logic tgt_answer(input bus_smp_t s);
        return s.trdy | s.stop;
    endfunction

    function automatic logic phase_complete(input bus_smp_t s);
        return s.irdy & tgt_answer(s);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pci_lat_tracker.sv
module pci_lat_tracker
    import pci_lat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t smp,
    output logic     txn_start,
    output logic     phase_done,
    output logic     live,
    output logic     first_phase,
    output logic     in_txn
);

    tx_state_t st_q;
    logic      frame_q;
    logic      first_q;
    logic      done_any_q;
    logic      txn_end;

    // Start on the first clock where FRAME# is seen asserted after being idle
    assign txn_start  = (st_q == TX_IDLE) && smp.frame && !frame_q;
    assign phase_done = (st_q == TX_BUSY) && phase_complete(smp);
    assign txn_end    = (st_q == TX_BUSY) && !smp.frame && !smp.irdy && done_any_q;
    assign live       = (st_q == TX_BUSY) && !txn_end;
    assign first_phase = first_q;
    assign in_txn     = (st_q == TX_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= TX_IDLE;
            frame_q    <= 1'b0;
            first_q    <= 1'b0;
            done_any_q <= 1'b0;
        end else begin
            frame_q <= smp.frame;
            case (st_q)
                TX_IDLE: begin
                    if (txn_start) begin
                        st_q       <= TX_BUSY;
                        first_q    <= 1'b1;
                        done_any_q <= 1'b0;
                    end
                end
                TX_BUSY: begin
                    if (txn_end) begin
                        st_q <= TX_IDLE;
                    end else if (phase_done) begin
                        first_q    <= 1'b0;
                        done_any_q <= 1'b1;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pci_lat_timer.sv
module pci_lat_timer
    import pci_lat_pkg::*;
#(
    parameter int FIRST_LIM = 16,
    parameter int NEXT_LIM  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic live,
    input  logic first_phase,
    input  logic resp,
    output logic breach
);

    // Saturation point lies one past the larger limit, so a limit is matched once
    localparam int CNT_MAX = max2(FIRST_LIM, NEXT_LIM) + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             ok_q;

    always_comb limit = first_phase ? CNT_W'(FIRST_LIM) : CNT_W'(NEXT_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else if (restart) begin
            cnt_q <= CNT_W'(1);
            ok_q  <= 1'b0;
        end else if (live) begin
            if (resp) begin
                ok_q <= 1'b1;
            end
            if (cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end
    end

    // Deadline clock reached with no answer yet: breach on this sample
    assign breach = live && !ok_q && !resp && (cnt_q == limit);

endmodule

// File: rtl/pci_lat_regs.sv
module pci_lat_regs
    import pci_lat_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  lat_flags_t        hit,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output lat_flags_t        sts,
    output lat_flags_t        msk,
    output logic              irq
);

    localparam logic [DATA_W-1:0] TGT_SEL = DATA_W'(1) << TGT_FLAG_BIT;
    localparam logic [DATA_W-1:0] MST_SEL = DATA_W'(1) << MST_FLAG_BIT;

    lat_flags_t sts_q;
    lat_flags_t msk_q;
    lat_flags_t wbits;
    logic       wr_sts;
    logic       wr_msk;

    assign wr_sts    = reg_wr && (reg_addr == ADDR_W'(REG_STATUS_ADDR));
    assign wr_msk    = reg_wr && (reg_addr == ADDR_W'(REG_MASK_ADDR));
    assign wbits.tgt = |(reg_wdata & TGT_SEL);
    assign wbits.mst = |(reg_wdata & MST_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            msk_q <= '{tgt: 1'b1, mst: 1'b1};
        end else begin
            // New events are ORed in after the clear, so they win
            if (wr_sts) begin
                sts_q <= lat_flags_t'((sts_q & ~wbits) | hit);
            end else begin
                sts_q <= lat_flags_t'(sts_q | hit);
            end
            if (wr_msk) begin
                msk_q <= wbits;
            end
        end
    end

    function automatic logic [DATA_W-1:0] place(input lat_flags_t f);
        logic [DATA_W-1:0] v;
        v = '0;
        v[TGT_FLAG_BIT] = f.tgt;
        v[MST_FLAG_BIT] = f.mst;
        return v;
    endfunction

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_STATUS_ADDR)) begin
            reg_rdata = place(sts_q);
        end else if (reg_addr == ADDR_W'(REG_MASK_ADDR)) begin
            reg_rdata = place(msk_q);
        end
    end

    assign sts = sts_q;
    assign msk = msk_q;
    assign irq = |(sts_q & ~msk_q);

endmodule

// File: rtl/pci_lat_monitor.sv
module pci_lat_monitor
    import pci_lat_pkg::*;
#(
    parameter int TGT_INIT_LIM = 16,
    parameter int TGT_NEXT_LIM = 8,
    parameter int MST_LIM      = 8,
    parameter int ADDR_W       = 2,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int NUM_KINDS = 2;  // index 0 target, index 1 master
    localparam int FIRST_LIMS [NUM_KINDS] = '{TGT_INIT_LIM, MST_LIM};
    localparam int NEXT_LIMS  [NUM_KINDS] = '{TGT_NEXT_LIM, MST_LIM};

    bus_smp_t   smp;
    logic       txn_start;
    logic       phase_done;
    logic       live;
    logic       first_phase;
    logic       in_txn;
    logic       restart;
    logic [NUM_KINDS-1:0] resp;
    logic [NUM_KINDS-1:0] breach;
    logic       tgt_breach;
    logic       mst_breach;
    lat_flags_t hit;
    lat_flags_t sts;
    lat_flags_t msk;

    assign smp     = decode_bus(frame_n, irdy_n, trdy_n, stop_n);
    assign restart = txn_start | phase_done;
    assign resp[0] = tgt_answer(smp);
    assign resp[1] = smp.irdy;

    pci_lat_tracker u_trk (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .txn_start   (txn_start),
        .phase_done  (phase_done),
        .live        (live),
        .first_phase (first_phase),
        .in_txn      (in_txn)
    );

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_tmr
        pci_lat_timer #(
            .FIRST_LIM (FIRST_LIMS[g]),
            .NEXT_LIM  (NEXT_LIMS[g])
        ) u_tmr (
            .clk         (clk),
            .rst         (rst),
            .restart     (restart),
            .live        (live),
            .first_phase (first_phase),
            .resp        (resp[g]),
            .breach      (breach[g])
        );
    end

    assign tgt_breach = breach[0];
    assign mst_breach = breach[1];
    assign hit.tgt    = tgt_breach;
    assign hit.mst    = mst_breach;

    pci_lat_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sts       (sts),
        .msk       (msk),
        .irq       (irq)
    );

endmodule

// File: rtl/pci_lat_monitor_chk.sv
module pci_lat_monitor_chk
    import pci_lat_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              stop_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              in_txn,
    input logic              tgt_breach,
    input logic              mst_breach,
    input logic              sts_tgt,
    input logic              sts_mst
);

    localparam logic [DATA_W-1:0] TGT_SEL = DATA_W'(1) << TGT_FLAG_BIT;

    logic clr_tgt;
    assign clr_tgt = reg_wr && (reg_addr == ADDR_W'(REG_STATUS_ADDR)) && |(reg_wdata & TGT_SEL);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    p_tgt_answer_r1: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n || !stop_n) |-> !tgt_breach);

    p_mst_answer_r3: assert property (@(posedge clk) disable iff (rst)
        !irdy_n |-> !mst_breach);

    p_idle_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (!in_txn || frame_n && irdy_n && !in_txn) |-> (!tgt_breach && !mst_breach));

    p_tgt_record_r7: assert property (@(posedge clk) disable iff (rst)
        tgt_breach |=> sts_tgt);

    p_mst_record_r7: assert property (@(posedge clk) disable iff (rst)
        mst_breach |=> sts_mst);

    p_tgt_once_r8: assert property (@(posedge clk) disable iff (rst)
        tgt_breach |=> !tgt_breach);

    p_mst_once_r8: assert property (@(posedge clk) disable iff (rst)
        mst_breach |=> !mst_breach);

    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_tgt && !tgt_breach) |=> !sts_tgt);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_tgt && !clr_tgt) |=> sts_tgt);

endmodule

bind pci_lat_monitor pci_lat_monitor_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .in_txn     (in_txn),
    .tgt_breach (tgt_breach),
    .mst_breach (mst_breach),
    .sts_tgt    (sts.tgt),
    .sts_mst    (sts.mst)
);

// File: tb/sim_pci_lat_monitor.sv
module sim_pci_lat_monitor;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        stop_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    pci_lat_monitor u0 (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .stop_n    (stop_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Behavioural reference: waits counted in plain integers, no saturation
    bit m_in, m_first, m_done_any, m_fq, m_tok, m_mok;
    bit m_st, m_sm, m_kt, m_km;
    int m_tw, m_mw;

    always @(posedge clk) begin
        bit tr, ir, set_t, set_m;
        if (rst) begin
            m_in = 0; m_first = 0; m_done_any = 0; m_fq = 0; m_tok = 0; m_mok = 0;
            m_st = 0; m_sm = 0; m_kt = 1; m_km = 1; m_tw = 0; m_mw = 0;
        end else begin
            tr = !trdy_n || !stop_n;
            ir = !irdy_n;
            set_t = 0;
            set_m = 0;
            if (!m_in) begin
                if (!frame_n && !m_fq) begin
                    m_in = 1; m_first = 1; m_done_any = 0;
                    m_tw = 0; m_mw = 0; m_tok = 0; m_mok = 0;
                end
            end else if (frame_n && irdy_n && m_done_any) begin
                m_in = 0;
            end else begin
                m_tw++;
                m_mw++;
                if (!tr && !m_tok && m_tw == (m_first ? 16 : 8)) set_t = 1;
                if (!ir && !m_mok && m_mw == 8) set_m = 1;
                if (tr) m_tok = 1;
                if (ir) m_mok = 1;
                if (tr && ir) begin
                    m_first = 0; m_done_any = 1;
                    m_tw = 0; m_mw = 0; m_tok = 0; m_mok = 0;
                end
            end
            if (reg_wr && reg_addr == 2'd0) begin
                if (reg_wdata[12]) m_st = 0;
                if (reg_wdata[11]) m_sm = 0;
            end
            if (reg_wr && reg_addr == 2'd1) begin
                m_kt = reg_wdata[12];
                m_km = reg_wdata[11];
            end
            if (set_t) m_st = 1;
            if (set_m) m_sm = 1;
            m_fq = !frame_n;
        end
    end

    task automatic compare();
        logic [15:0] exp_rd;
        logic        exp_irq;
        exp_irq = (m_st && !m_kt) || (m_sm && !m_km);
        case (reg_addr)
            2'd0:    exp_rd = {3'b000, m_st, m_sm, 11'h0};
            2'd1:    exp_rd = {3'b000, m_kt, m_km, 11'h0};
            default: exp_rd = 16'h0;
        endcase
        checks += 2;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL R11 irq actual %0b expected %0b at %0t", irq, exp_irq, $time);
        end
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL R5 rdata actual %h expected %h at %0t", reg_rdata, exp_rd, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(PER/4);
        compare();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input bit f, input bit i, input bit t, input bit s);
        frame_n = f; irdy_n = i; trdy_n = t; stop_n = s;
        step();
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #1;
        v = int'(reg_rdata);
        reg_addr = 2'd0;
        #1;
    endtask

    task automatic wreg(input int a, input int d);
        reg_addr = 2'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 16'h0;
    endtask

    // n phases; tl/ml are the response clocks counted from each phase's reference
    task automatic txn(input int n, input int tl0, input int ml0,
                       input int tln, input int mln, input bit use_stop);
        drive(0, 1, 1, 1);
        for (int p = 0; p < n; p++) begin
            int tl, ml, fin;
            tl = (p == 0) ? tl0 : tln;
            ml = (p == 0) ? ml0 : mln;
            fin = (tl > ml) ? tl : ml;
            for (int k = 1; k <= fin; k++) begin
                bit last;
                last = (p == n - 1) && (k >= ml);
                drive(last, !(k >= ml), !(k >= tl && !use_stop), !(k >= tl && use_stop));
            end
        end
        drive(1, 1, 1, 1);
    endtask

    task automatic clr_at(input int edges);
        repeat (edges) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h1800;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #(PER/4);
        rst = 1'b0;
        // R10 reset state
        rd(0, v); chk("R10 status", v, 'h0000);
        rd(1, v); chk("R10 mask", v, 'h1800);
        chk("R10 irq", int'(irq), 0);
        step();
        wreg(1, 0);

        // R1 first target phase: 16th clock legal (TRDY and STOP), 17th late
        txn(1, 16, 1, 8, 8, 0);
        rd(0, v); chk("R1 trdy on 16", v, 'h0000);
        txn(1, 16, 1, 8, 8, 1);
        rd(0, v); chk("R1 stop on 16", v, 'h0000);
        txn(1, 17, 1, 8, 8, 0);
        rd(0, v); chk("R1 late target", v, 'h1000);
        chk("R11 irq on unmasked flag", int'(irq), 1);
        wreg(0, 'h1800);

        // R2 later target phases
        txn(3, 4, 1, 8, 1, 0);
        rd(0, v); chk("R2 target on 8", v, 'h0000);
        txn(3, 4, 1, 9, 1, 0);
        rd(0, v); chk("R2 late target", v, 'h1000);
        wreg(0, 'h1800);

        // R3 first master phase
        txn(1, 8, 8, 8, 8, 0);
        rd(0, v); chk("R3 irdy on 8", v, 'h0000);
        txn(1, 10, 9, 8, 8, 0);
        rd(0, v); chk("R3 late master", v, 'h0800);
        wreg(0, 'h1800);

        // R4 later master phases
        txn(3, 2, 1, 2, 8, 0);
        rd(0, v); chk("R4 irdy on 8", v, 'h0000);
        txn(3, 2, 1, 2, 9, 0);
        rd(0, v); chk("R4 late master", v, 'h0800);
        wreg(0, 'h1800);

        // R5 layout and unused addresses
        wreg(1, 'hFFFF);
        rd(1, v); chk("R5 mask readback", v, 'h1800);
        rd(2, v); chk("R5 unused addr 2", v, 'h0000);
        rd(3, v); chk("R5 unused addr 3", v, 'h0000);

        // R6 masked breach still recorded
        txn(1, 17, 1, 8, 8, 0);
        rd(0, v); chk("R6 status recorded", v, 'h1000);
        chk("R6 irq masked", int'(irq), 0);
        wreg(1, 'h0800);
        chk("R11 irq after unmask", int'(irq), 1);

        // R7 write-one-to-clear per bit
        wreg(0, 'h0800);
        rd(0, v); chk("R7 other bit kept", v, 'h1000);
        wreg(0, 'h0000);
        rd(0, v); chk("R7 zero write kept", v, 'h1000);
        wreg(0, 'h1000);
        rd(0, v); chk("R7 cleared", v, 'h0000);
        wreg(1, 0);

        // R7 breach on the same clock as a clear wins
        fork
            txn(1, 17, 1, 8, 8, 0);
            clr_at(16);
        join
        rd(0, v); chk("R7 set wins", v, 'h1000);
        wreg(0, 'h1800);

        // R8 hung phase reports once
        fork
            txn(1, 40, 1, 8, 8, 0);
            clr_at(25);
        join
        rd(0, v); chk("R8 no repeat", v, 'h0000);
        txn(1, 30, 30, 8, 8, 0);
        rd(0, v); chk("R8 both once", v, 'h1800);
        wreg(0, 'h1800);

        // R9 exact limits across many phases, back-to-back, long idle
        txn(5, 16, 8, 8, 8, 0);
        txn(4, 3, 2, 8, 8, 0);
        rd(0, v); chk("R9 phase restart", v, 'h0000);
        for (int c = 0; c < 60; c++) drive(1, 1, 1, 1);
        rd(0, v); chk("R9 idle quiet", v, 'h0000);
        chk("R9 irq idle", int'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule